// File: doc/BRIEF.md
# Shared Rank-One and Matrix-Vector Multiplier

This block produces the two products an adaptive filter needs in each update step. One result is a scaled outer product, k1 · Mᵀ · M, which gives an N×N matrix. The other is a scaled matrix-vector product, k2 · R · Mᵀ, which gives an N-element vector. The row vector M and the matrix R sit in local memories that are loaded through write ports. The two scalars are inputs, captured when a run is accepted. The results land in two result memories, and each of these has a read port.

Two start pulses select the function. The same datapath serves both modes: a first multiplier, a second multiplier and one saturating accumulator, arranged as a pipeline. The vector length N is a runtime input, so one instance can handle a new size on every run. All values are signed Q8.16 fixed point held in 24 bits. NMAX must be a power of two, because element (i, j) of a matrix sits at address i·NMAX + j.

Top module: `rank1_mv_mul`

## Requirements
- R1: A start_outer pulse accepted while idle writes the outer-product memory at address i·NMAX+j, for every i, j < N, with qmul(qmul(k1, M[i]), M[j]).
- R2: A start_matvec pulse accepted while idle writes vector entry i, for every i < N, with qmul(k2, S_i). S_i is the saturating sum over j < N of qmul(R[i·NMAX+j], M[j]), summed in increasing j.
- R3: qmul(a, b) takes the exact product a·b of two Q8.16 words. It adds 2^15, shifts right by 16 with arithmetic rounding toward minus infinity (so halves round up), and clamps the result to [-2^23, 2^23-1].
- R4: Every addition in the accumulator is clamped to [-2^23, 2^23-1] before the next term is added.
- R5: The size input is sampled when a start is accepted. A value of 0 acts as 1 and a value above NMAX acts as NMAX. Successive runs may use different sizes.
- R6: A run leaves untouched every result entry whose row or column index is not below its effective N.
- R7: done is high for exactly one cycle. It rises on clock edge N²+1 (outer) or N²+2 (matrix-vector), counted from the edge that accepts the start.
- R8: busy is high from the edge that accepts a start through the done cycle. A start pulse seen while busy is high starts nothing and writes nothing.
- R9: If both start pulses arrive in the same idle cycle, the outer product runs.
- R10: k1, k2 and size are captured on acceptance. Changing them during a run does not change that run's results.
- R11: After reset, busy and done are low and every entry of both result memories reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_we | input | 1 | Write enable of the M vector memory |
| m_waddr | input | 3 | M write index |
| m_wdata | input | 24 | M write data, Q8.16 |
| r_we | input | 1 | Write enable of the R matrix memory |
| r_waddr | input | 6 | R write address, row·NMAX+column |
| r_wdata | input | 24 | R write data, Q8.16 |
| k1 | input | 24 | Outer-product scale, Q8.16 |
| k2 | input | 24 | Matrix-vector scale, Q8.16 |
| size | input | 4 | Vector length N for the next run |
| start_outer | input | 1 | Start the k1·Mᵀ·M run |
| start_matvec | input | 1 | Start the k2·R·Mᵀ run |
| op_raddr | input | 6 | Outer-product result read address |
| op_rdata | output | 24 | Outer-product result read data, combinational |
| mv_raddr | input | 3 | Vector result read index |
| mv_rdata | output | 24 | Vector result read data, combinational |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of collision are possible. A start of either kind can arrive in the same cycle as the other start, or in a cycle when a run is still in flight, including the done cycle itself. The bench raises both start lines together while the block is idle, and expects a full outer-product result and no vector writes. It also pulses the other start in the middle of a run and again in the done cycle. It then judges the outcome by checking that the run's latency is unchanged, that no second done appears, and that the vector memory keeps its previous contents.

// File: rtl/rmv_pkg.sv
package rmv_pkg;

  typedef enum logic {MODE_OUTER = 1'b0, MODE_MATVEC = 1'b1} rmv_mode_e;

  // Clamp a wide signed value into a dw-bit signed range.
  function automatic logic signed [63:0] fx_clamp(input logic signed [63:0] v,
                                                  input int unsigned dw);
    logic signed [63:0] hi, lo;
    hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (dw - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Round a double-precision product (half up) back to frac bits, then clamp.
  function automatic logic signed [63:0] fx_round_clamp(input logic signed [63:0] p,
                                                        input int unsigned frac,
                                                        input int unsigned dw);
    logic signed [63:0] r;
    r = (p + (64'sd1 <<< (frac - 1))) >>> frac;
    return fx_clamp(r, dw);
  endfunction

endpackage

// File: rtl/rmv_mem.sv
module rmv_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 24,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*DW +: DW] = cells[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/rmv_seq.sv
module rmv_seq
  import rmv_pkg::*;
#(
  parameter int NMAX = 8,
  localparam int IW  = $clog2(NMAX),
  localparam int SW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_outer,
  input  logic          start_matvec,
  input  logic [SW-1:0] size,
  input  logic          busy,
  output logic          accept,
  output rmv_mode_e     mode,
  output logic [SW-1:0] n_eff,
  output logic          iss_v,
  output logic [IW-1:0] iss_i,
  output logic [IW-1:0] iss_j,
  output logic          iss_first,
  output logic          iss_lastcol,
  output logic          iss_final
);
  logic          run;
  logic [IW-1:0] row, col;
  logic [SW-1:0] n_clamp;
  logic          col_end, row_end;

  assign accept  = (start_outer | start_matvec) & ~busy;
  assign n_clamp = (size == '0) ? SW'(1) :
                   (size > SW'(NMAX)) ? SW'(NMAX) : size;

  assign col_end = ({1'b0, col} == n_eff - SW'(1));
  assign row_end = ({1'b0, row} == n_eff - SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      row   <= '0;
      col   <= '0;
      mode  <= MODE_OUTER;
      n_eff <= SW'(1);
    end else if (accept) begin
      run   <= 1'b1;
      row   <= '0;
      col   <= '0;
      mode  <= start_outer ? MODE_OUTER : MODE_MATVEC;
      n_eff <= n_clamp;
    end else if (run) begin
      if (col_end) begin
        col <= '0;
        if (row_end) run <= 1'b0;
        else         row <= row + IW'(1);
      end else begin
        col <= col + IW'(1);
      end
    end
  end

  assign iss_v       = run;
  assign iss_i       = row;
  assign iss_j       = col;
  assign iss_first   = (col == '0);
  assign iss_lastcol = col_end;
  assign iss_final   = run & col_end & row_end;
endmodule

// File: rtl/rmv_dp.sv
module rmv_dp
  import rmv_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int DW   = 24,
  parameter int FRAC = 16,
  localparam int IW  = $clog2(NMAX),
  localparam int AW  = 2 * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] k1_in,
  input  logic [DW-1:0] k2_in,
  input  rmv_mode_e     mode,
  input  logic          iss_v,
  input  logic [IW-1:0] iss_i,
  input  logic [IW-1:0] iss_j,
  input  logic          iss_first,
  input  logic          iss_lastcol,
  input  logic          iss_final,
  input  logic [DW-1:0] m_i,
  input  logic [DW-1:0] m_j,
  input  logic [DW-1:0] r_ij,
  output logic          op_we,
  output logic [AW-1:0] op_waddr,
  output logic [DW-1:0] op_wdata,
  output logic          mv_we,
  output logic [IW-1:0] mv_waddr,
  output logic [DW-1:0] mv_wdata,
  output logic          final_wr,
  output logic          pipe_busy
);
  function automatic logic signed [DW-1:0] qmul(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = a * b;
    return DW'(fx_round_clamp(64'(p), FRAC, DW));
  endfunction

  function automatic logic signed [DW-1:0] qadd(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [DW:0] s;
    s = DW'(a) + DW'(b);
    s = (DW+1)'(a) + (DW+1)'(b);
    return DW'(fx_clamp(64'(s), DW));
  endfunction

  logic signed [DW-1:0] k1_q, k2_q;
  // stage 1: first multiplier
  logic                 v1, first1, lastc1, fin1;
  logic [IW-1:0]        i1, j1;
  logic signed [DW-1:0] p1, mj1;
  // stage 2: accumulator result held for the vector write
  logic                 v2, fin2;
  logic [IW-1:0]        i2;
  logic signed [DW-1:0] acc, acc_next, acc_done;
  // multiplier operands
  logic signed [DW-1:0] ma_a, ma_b, mb_a, mb_b, mb_y;

  always_comb begin
    if (mode == MODE_OUTER) begin
      ma_a = k1_q;
      ma_b = m_i;
      mb_a = p1;
      mb_b = mj1;
    end else begin
      ma_a = r_ij;
      ma_b = m_j;
      mb_a = k2_q;
      mb_b = acc_done;
    end
  end

  assign mb_y     = qmul(mb_a, mb_b);
  assign acc_next = first1 ? p1 : qadd(acc, p1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k1_q <= '0;
      k2_q <= '0;
      v1 <= 1'b0; first1 <= 1'b0; lastc1 <= 1'b0; fin1 <= 1'b0;
      i1 <= '0; j1 <= '0; p1 <= '0; mj1 <= '0;
    end else begin
      if (accept) begin
        k1_q <= k1_in;
        k2_q <= k2_in;
      end
      v1     <= iss_v;
      first1 <= iss_first;
      lastc1 <= iss_lastcol;
      fin1   <= iss_final;
      i1     <= iss_i;
      j1     <= iss_j;
      p1     <= qmul(ma_a, ma_b);
      mj1    <= m_j;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; fin2 <= 1'b0; i2 <= '0;
      acc <= '0; acc_done <= '0;
    end else begin
      v2   <= 1'b0;
      fin2 <= 1'b0;
      if (v1 && mode == MODE_MATVEC) begin
        acc <= acc_next;
        if (lastc1) begin
          v2       <= 1'b1;
          fin2     <= fin1;
          i2       <= i1;
          acc_done <= acc_next;
        end
      end
    end
  end

  assign op_we    = v1 & (mode == MODE_OUTER);
  assign op_waddr = {i1, j1};
  assign op_wdata = mb_y;
  assign mv_we    = v2;
  assign mv_waddr = i2;
  assign mv_wdata = mb_y;
  assign final_wr = (op_we & fin1) | (mv_we & fin2);
  assign pipe_busy = v1 | v2;
endmodule

// File: rtl/rank1_mv_mul.sv
module rank1_mv_mul
  import rmv_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int DW   = 24,
  parameter int FRAC = 16,
  localparam int IW  = $clog2(NMAX),
  localparam int AW  = 2 * IW,
  localparam int SW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_we,
  input  logic [IW-1:0] m_waddr,
  input  logic [DW-1:0] m_wdata,
  input  logic          r_we,
  input  logic [AW-1:0] r_waddr,
  input  logic [DW-1:0] r_wdata,
  input  logic [DW-1:0] k1,
  input  logic [DW-1:0] k2,
  input  logic [SW-1:0] size,
  input  logic          start_outer,
  input  logic          start_matvec,
  input  logic [AW-1:0] op_raddr,
  output logic [DW-1:0] op_rdata,
  input  logic [IW-1:0] mv_raddr,
  output logic [DW-1:0] mv_rdata,
  output logic          busy,
  output logic          done
);
  rmv_mode_e     mode;
  logic          accept, iss_v, iss_first, iss_lastcol, iss_final;
  logic [IW-1:0] iss_i, iss_j;
  logic [SW-1:0] n_eff;
  logic [DW-1:0] m_i, m_j, r_ij;
  logic          op_we, mv_we, final_wr, pipe_busy;
  logic [AW-1:0] op_waddr;
  logic [IW-1:0] mv_waddr;
  logic [DW-1:0] op_wdata, mv_wdata;
  logic          done_q;

  assign busy = iss_v | pipe_busy | done_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= final_wr;
  end

  rmv_seq #(.NMAX(NMAX)) u_seq (
    .clk, .rst_n, .start_outer, .start_matvec, .size, .busy,
    .accept, .mode, .n_eff, .iss_v, .iss_i, .iss_j,
    .iss_first, .iss_lastcol, .iss_final
  );

  rmv_mem #(.DEPTH(NMAX), .DW(DW), .NRD(2)) u_mmem (
    .clk, .rst_n, .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr({iss_j, iss_i}), .rdata({m_j, m_i})
  );

  rmv_mem #(.DEPTH(NMAX*NMAX), .DW(DW), .NRD(1)) u_rmem (
    .clk, .rst_n, .we(r_we), .waddr(r_waddr), .wdata(r_wdata),
    .raddr({iss_i, iss_j}), .rdata(r_ij)
  );

  rmv_dp #(.NMAX(NMAX), .DW(DW), .FRAC(FRAC)) u_dp (
    .clk, .rst_n, .accept, .k1_in(k1), .k2_in(k2), .mode,
    .iss_v, .iss_i, .iss_j, .iss_first, .iss_lastcol, .iss_final,
    .m_i, .m_j, .r_ij,
    .op_we, .op_waddr, .op_wdata, .mv_we, .mv_waddr, .mv_wdata,
    .final_wr, .pipe_busy
  );

  rmv_mem #(.DEPTH(NMAX*NMAX), .DW(DW), .NRD(1)) u_opmem (
    .clk, .rst_n, .we(op_we), .waddr(op_waddr), .wdata(op_wdata),
    .raddr(op_raddr), .rdata(op_rdata)
  );

  rmv_mem #(.DEPTH(NMAX), .DW(DW), .NRD(1)) u_mvmem (
    .clk, .rst_n, .we(mv_we), .waddr(mv_waddr), .wdata(mv_wdata),
    .raddr(mv_raddr), .rdata(mv_rdata)
  );
endmodule

// File: rtl/rank1_mv_mul_chk.sv
module rank1_mv_mul_chk #(
  parameter int NMAX = 8,
  localparam int IW  = $clog2(NMAX),
  localparam int AW  = 2 * IW,
  localparam int SW  = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          op_we,
  input logic          mv_we,
  input logic [AW-1:0] op_waddr,
  input logic [IW-1:0] mv_waddr,
  input logic [SW-1:0] n_eff
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_we || mv_we)); // R7
  AST_ONE_RESULT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_we && mv_we)); // R9
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we || mv_we) |-> busy); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8
  AST_OP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |-> ({1'b0, op_waddr[AW-1:IW]} < n_eff && {1'b0, op_waddr[IW-1:0]} < n_eff)); // R6
  AST_MV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_we |-> ({1'b0, mv_waddr} < n_eff)); // R6
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(n_eff)); // R10
endmodule

bind rank1_mv_mul rank1_mv_mul_chk #(.NMAX(NMAX)) u_chk (
  .clk, .rst_n, .busy, .done, .op_we, .mv_we, .op_waddr, .mv_waddr, .n_eff
);

// File: tb/rank1_mv_mul_test.sv
module rank1_mv_mul_test;
  localparam int NMAX = 8;
  localparam int DW   = 24;
  localparam longint HI = 64'sd8388607;
  localparam longint LO = -64'sd8388608;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_we = 0, r_we = 0, start_outer = 0, start_matvec = 0;
  logic [2:0] m_waddr = 0, mv_raddr = 0;
  logic [5:0] r_waddr = 0, op_raddr = 0;
  logic [23:0] m_wdata = 0, r_wdata = 0, k1 = 0, k2 = 0;
  logic [3:0] size = 0;
  logic [23:0] op_rdata, mv_rdata;
  logic busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;
  longint mM [NMAX];
  longint mR [NMAX*NMAX];
  longint opx [NMAX*NMAX];
  longint mvx [NMAX];

  rank1_mv_mul uut (.*);

  always #5 clk = ~clk;

  function automatic longint sx(input logic [23:0] v);
    return longint'(signed'(v));
  endfunction

  function automatic longint clampq(input longint v);
    return (v > HI) ? HI : (v < LO) ? LO : v;
  endfunction

  // floor((a*b + 2^15) / 2^16), clamped
  function automatic longint qm(input longint a, input longint b);
    longint t;
    t = a * b + 32768;
    if (t >= 0) t = t / 65536;
    else        t = -((-t + 65535) / 65536);
    return clampq(t);
  endfunction

  function automatic int neff(input int s);
    return (s == 0) ? 1 : (s > NMAX) ? NMAX : s;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  task automatic load_m(input int idx, input longint v);
    @(negedge clk); m_we = 1; m_waddr = 3'(idx); m_wdata = 24'(v); mM[idx] = v;
    @(negedge clk); m_we = 0;
  endtask

  task automatic load_r(input int idx, input longint v);
    @(negedge clk); r_we = 1; r_waddr = 6'(idx); r_wdata = 24'(v); mR[idx] = v;
    @(negedge clk); r_we = 0;
  endtask

  function automatic longint rnd(input int shift);
    return sx(24'($urandom)) >>> shift;
  endfunction

  task automatic check_mems(input string req);
    for (int a = 0; a < NMAX*NMAX; a++) begin
      @(negedge clk); op_raddr = 6'(a); #1;
      chk(req, sx(op_rdata), opx[a]);
    end
    for (int a = 0; a < NMAX; a++) begin
      @(negedge clk); mv_raddr = 3'(a); #1;
      chk(req, sx(mv_rdata), mvx[a]);
    end
  endtask

  // mode 0 outer, 1 matvec, 2 both starts; disturb: 1 = other start mid-run and in done cycle,
  // plus scalar/size change mid-run
  task automatic run(input int mode, input int sz, input longint kk1, input longint kk2,
                     input int disturb, input string req);
    int n, lat, cnt;
    longint s;
    n = neff(sz);
    if (mode != 1) begin
      for (int i = 0; i < n; i++)
        for (int j = 0; j < n; j++)
          opx[i*NMAX+j] = qm(qm(kk1, mM[i]), mM[j]);
      lat = n*n + 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        s = 0;
        for (int j = 0; j < n; j++) s = clampq(s + qm(mR[i*NMAX+j], mM[j]));
        mvx[i] = qm(kk2, s);
      end
      lat = n*n + 2;
    end
    @(negedge clk);
    size = 4'(sz); k1 = 24'(kk1); k2 = 24'(kk2);
    start_outer = (mode != 1); start_matvec = (mode != 0);
    cnt = 0;
    forever begin
      @(negedge clk);
      start_outer = 0; start_matvec = 0;
      cnt++;
      if (disturb != 0 && cnt == 3) begin
        chk("R8 busy during run", busy, 1);
        k1 = 24'($urandom); k2 = 24'($urandom); size = 4'($urandom);
        if (mode == 1) start_outer = 1; else start_matvec = 1;
      end
      if (done || cnt > 5000) break;
    end
    chk({req, " R7 latency"}, cnt - 1, lat);
    chk("R8 busy in done cycle", busy, 1);
    if (disturb != 0) begin
      if (mode == 1) start_outer = 1; else start_matvec = 1;
    end
    @(negedge clk);
    start_outer = 0; start_matvec = 0;
    chk("R7 done single cycle", done, 0);
    if (disturb != 0) begin
      cnt = 0;
      for (int c = 0; c < 150; c++) begin @(negedge clk); if (done || busy) cnt++; end
      chk("R8 ignored start produced no run", cnt, 0);
    end else begin
      @(negedge clk);
    end
    chk("R8 idle after run", busy, 0);
    check_mems(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < NMAX*NMAX; a++) begin opx[a] = 0; mR[a] = 0; end
    for (int a = 0; a < NMAX; a++) begin mvx[a] = 0; mM[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    check_mems("R11 reset contents");

    // random full-size runs
    for (int a = 0; a < NMAX; a++) load_m(a, rnd(4));
    for (int a = 0; a < NMAX*NMAX; a++) load_r(a, rnd(4));
    run(0, 8, rnd(3), 0, 0, "R1 outer N=8");
    run(1, 8, 0, rnd(3), 0, "R2 matvec N=8");

    // smaller size keeps the rest (R5, R6)
    for (int a = 0; a < NMAX; a++) load_m(a, rnd(2));
    run(0, 3, rnd(2), 0, 0, "R6 outer N=3 leaves rest");
    run(1, 5, 0, rnd(2), 0, "R6 matvec N=5 leaves rest");
    run(0, 0, rnd(3), 0, 0, "R5 size 0 acts as 1");
    run(1, 12, 0, rnd(3), 0, "R5 size above NMAX");

    // rounding corner cases (R3)
    load_m(0, 1); load_m(1, -1); load_m(2, 32768); load_m(3, -32768);
    run(0, 4, 32768, 0, 0, "R3 rounding k1=0.5");
    run(0, 4, -32768, 0, 0, "R3 rounding k1=-0.5");
    run(0, 4, HI, 0, 0, "R3 product clamp");

    // accumulator saturation (R4)
    for (int a = 0; a < NMAX; a++) load_m(a, HI);
    for (int a = 0; a < NMAX*NMAX; a++) load_r(a, (a < 32) ? HI : LO);
    load_r(1, 64'sd65536); load_r(2, -64'sd3000000);
    run(1, 8, 0, 65536, 0, "R4 accumulator clamp");
    run(1, 8, 0, -32768, 0, "R4 clamp then scale");

    // collisions (R8, R9, R10)
    for (int a = 0; a < NMAX; a++) load_m(a, rnd(5));
    for (int a = 0; a < NMAX*NMAX; a++) load_r(a, rnd(5));
    run(2, 6, rnd(3), rnd(3), 0, "R9 both starts");
    run(0, 7, rnd(3), 0, 1, "R10 outer disturbed");
    run(1, 7, 0, rnd(3), 1, "R10 matvec disturbed");

    for (int t = 0; t < 6; t++)
      run(t % 2, 1 + ($urandom % 8), rnd(2), rnd(2), 0, (t % 2) ? "R2 random" : "R1 random");

    finish_run();
  end
endmodule